// File: doc/BRIEF.md
# Serial-Load Bank Controller

This block is the bank-selection logic for one mapper mode of a cartridge memory controller. The host processor cannot write a whole register at once. Each write into the upper half of the address space carries a single data bit, and five such writes build one 5-bit value. That value then goes into one of four internal registers: control, character bank 0, character bank 1 or program bank. Address bits pick which register receives it on the fifth write. A write with the top data bit set abandons any load in progress and forces the program window layout back to its default.

The four registers are turned into bank numbers, which are registered one clock after the registers change:
- two 16K program window numbers (lower window at 0x8000, upper window at 0xC000);
- two 4K character window numbers;
- a 2-bit nametable mirroring mode.

A separate clear pulse, driven by the surrounding logic, restores the control and program registers and empties the serial loader. Writes are accepted only while the mode enable is high, so the block can sit beside other mapper modes that share the same write bus.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After reset the control register is 0x0C and every other register, the shift buffer and the write counter are zero. The outputs are therefore program low 0, program high 15, character low 0, character high 1 and mirroring 0.
- R2: Loading is least-significant bit first. Data bit 0 of the k-th accepted write (k = 0..4) lands in bit k of the assembled value, and data bits 6..1 have no effect.
- R3: The fifth accepted write stores the assembled value into the register selected by address bits 14:13 of that write (0 control, 1 character 0, 2 character 1, 3 program). It also returns the counter and buffer to zero.
- R4: A write counts only when wr_en and mode_en are both high and address bit 15 is 1. Any other write leaves the registers, buffer and counter untouched.
- R5: An accepted write with data bit 7 set clears the buffer and counter and sets control bits 3 and 2, keeping control bits 4, 1 and 0.
- R6: A ser_clear pulse sets control to 0x0C, sets the program register to 0 and clears the buffer and counter. It leaves both character registers unchanged and takes precedence over a write in the same cycle, which is then discarded.
- R7: Program windows, in 16K units, use program register bits 3:0 (call this P):
  - with control bit 3 clear, low = P with bit 0 cleared and high = low + 1;
  - with control bits 3:2 = 11, low = P and high = 15;
  - with control bits 3:2 = 10, low = 0 and high = P.
- R8: Character windows, in 4K units:
  - with control bit 4 set, low = character 0 and high = character 1;
  - with it clear, low = character 0 with bit 0 cleared and high = low + 1.
- R9: mirror_mode equals control bits 1:0, encoded 0 single-screen low, 1 single-screen high, 2 vertical, 3 horizontal.
- R10: The bank outputs change on the clock edge after the edge at which a register is written, not on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | High while this mapper mode is selected; gates all writes |
| ser_clear | input | 1 | Clear pulse for control, program and serial state |
| wr_en | input | 1 | Processor write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address; bit 15 qualifies, bits 14:13 select the register |
| wr_data | input | DATA_W | Write data; bit 0 is the serial bit, bit 7 aborts |
| prg_bank_lo | output | PRG_W | 16K bank mapped at 0x8000 |
| prg_bank_hi | output | PRG_W | 16K bank mapped at 0xC000 |
| chr_bank_lo | output | REG_W | 4K character bank for the lower pattern half |
| chr_bank_hi | output | REG_W | 4K character bank for the upper pattern half |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
The external clear and the serial commit can meet in one cycle. The bench does this by raising ser_clear on the same clock as the fifth write to the control register. The expected result is the clear state: control 0x0C, program 0 and character registers kept. A following full five-write load must then assemble correctly, which shows the counter really restarted at zero. A second collision is an abort write arriving with a partial load pending; the bench checks that the pending bits are dropped and that control keeps its mirroring and character-size bits.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

   // Bit positions inside the control register
   localparam int CTRL_B_CHR_SPLIT = 4;   // 1: two 4K character windows
   localparam int CTRL_B_PRG_SPLIT = 3;   // 1: two independent 16K program windows
   localparam int CTRL_B_LOW_SWAP  = 2;   // 1: bank at 0x8000, fixed last at 0xC000

   // Value forced into control on an abort, and control reset value
   localparam int CTRL_FORCE_VAL   = 12;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_CHR0 = 2'd1,
      SEL_CHR1 = 2'd2,
      SEL_PRG  = 2'd3
   } sbc_sel_e;

   typedef enum logic [1:0] {
      MIR_ONE_LO = 2'd0,
      MIR_ONE_HI = 2'd1,
      MIR_VERT   = 2'd2,
      MIR_HORZ   = 2'd3
   } sbc_mirror_e;

   localparam int NUM_REGS = 4;

   function automatic int reg_reset_val(input int idx);
      return (idx == int'(SEL_CTRL)) ? CTRL_FORCE_VAL : 0;
   endfunction

endpackage

// File: rtl/sbc_shift_loader.sv
module sbc_shift_loader #(
   parameter int REG_W = 5,
   parameter int CNT_W = $clog2(REG_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             wr_i,
   input  logic             abort_i,
   input  logic             bit_i,
   output logic             commit_o,
   output logic [REG_W-1:0] word_o,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(REG_W - 1);

   logic [REG_W-1:0] buf_q;
   logic [CNT_W-1:0] cnt_q;
   logic             take;
   logic             last;

   assign last     = (cnt_q == LAST_IDX);
   assign take     = wr_i & ~abort_i & ~clr_i;
   assign commit_o = take & last;
   assign word_o   = buf_q | (REG_W'(bit_i) << cnt_q);
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         cnt_q <= '0;
      end else if (clr_i || (wr_i && abort_i)) begin
         buf_q <= '0;
         cnt_q <= '0;
      end else if (take) begin
         if (last) begin
            buf_q <= '0;
            cnt_q <= '0;
         end else begin
            buf_q <= word_o;
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/sbc_reg_bank.sv
module sbc_reg_bank
   import sbc_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             abort_i,
   input  logic             commit_i,
   input  logic [1:0]       sel_i,
   input  logic [REG_W-1:0] word_i,
   output logic [REG_W-1:0] ctrl_o,
   output logic [REG_W-1:0] chr0_o,
   output logic [REG_W-1:0] chr1_o,
   output logic [REG_W-1:0] prg_o
);

   localparam logic [REG_W-1:0] FORCE_BITS = REG_W'(CTRL_FORCE_VAL);

   logic [REG_W-1:0] regs_q [NUM_REGS];

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      localparam logic [REG_W-1:0] RST_VAL   = REG_W'(reg_reset_val(gi));
      localparam bit               IS_CTRL   = (gi == int'(SEL_CTRL));
      localparam bit               CLR_HIT   = (gi == int'(SEL_CTRL)) || (gi == int'(SEL_PRG));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[gi] <= RST_VAL;
         end else if (clr_i) begin
            if (CLR_HIT) regs_q[gi] <= RST_VAL;
         end else if (commit_i && (sel_i == 2'(gi))) begin
            regs_q[gi] <= word_i;
         end else if (IS_CTRL && abort_i) begin
            regs_q[gi] <= regs_q[gi] | FORCE_BITS;
         end
      end
   end

   assign ctrl_o = regs_q[SEL_CTRL];
   assign chr0_o = regs_q[SEL_CHR0];
   assign chr1_o = regs_q[SEL_CHR1];
   assign prg_o  = regs_q[SEL_PRG];

endmodule

// File: rtl/sbc_bank_map.sv
module sbc_bank_map
   import sbc_pkg::*;
#(
   parameter int REG_W   = 5,
   parameter int PRG_W   = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] ctrl_i,
   input  logic [REG_W-1:0] chr0_i,
   input  logic [REG_W-1:0] chr1_i,
   input  logic [REG_W-1:0] prg_i,
   output logic [PRG_W-1:0] prg_lo_o,
   output logic [PRG_W-1:0] prg_hi_o,
   output logic [REG_W-1:0] chr_lo_o,
   output logic [REG_W-1:0] chr_hi_o,
   output logic [1:0]       mirror_o
);

   localparam logic [PRG_W-1:0] PRG_LAST = {PRG_W{1'b1}};

   logic [PRG_W-1:0] bank;
   logic [PRG_W-1:0] prg_lo_d, prg_hi_d;
   logic [REG_W-1:0] chr_lo_d, chr_hi_d;
   logic [1:0]       mirror_d;

   assign bank = prg_i[PRG_W-1:0];

   always_comb begin
      if (!ctrl_i[CTRL_B_PRG_SPLIT]) begin
         prg_lo_d = {bank[PRG_W-1:1], 1'b0};
         prg_hi_d = {bank[PRG_W-1:1], 1'b1};
      end else if (ctrl_i[CTRL_B_LOW_SWAP]) begin
         prg_lo_d = bank;
         prg_hi_d = PRG_LAST;
      end else begin
         prg_lo_d = '0;
         prg_hi_d = bank;
      end
   end

   always_comb begin
      if (ctrl_i[CTRL_B_CHR_SPLIT]) begin
         chr_lo_d = chr0_i;
         chr_hi_d = chr1_i;
      end else begin
         chr_lo_d = {chr0_i[REG_W-1:1], 1'b0};
         chr_hi_d = {chr0_i[REG_W-1:1], 1'b1};
      end
   end

   assign mirror_d = ctrl_i[1:0];

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prg_lo_o <= '0;
            prg_hi_o <= PRG_LAST;
            chr_lo_o <= '0;
            chr_hi_o <= REG_W'(1);
            mirror_o <= MIR_ONE_LO;
         end else begin
            prg_lo_o <= prg_lo_d;
            prg_hi_o <= prg_hi_d;
            chr_lo_o <= chr_lo_d;
            chr_hi_o <= chr_hi_d;
            mirror_o <= mirror_d;
         end
      end
   end else begin : g_out_comb
      assign prg_lo_o = prg_lo_d;
      assign prg_hi_o = prg_hi_d;
      assign chr_lo_o = chr_lo_d;
      assign chr_hi_o = chr_hi_d;
      assign mirror_o = mirror_d;
   end

endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
   import sbc_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int REG_W   = 5,
   parameter int PRG_W   = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_en,
   input  logic              ser_clear,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [PRG_W-1:0]  prg_bank_lo,
   output logic [PRG_W-1:0]  prg_bank_hi,
   output logic [REG_W-1:0]  chr_bank_lo,
   output logic [REG_W-1:0]  chr_bank_hi,
   output logic [1:0]        mirror_mode
);

   localparam int CNT_W   = $clog2(REG_W + 1);
   localparam int WIN_BIT = ADDR_W - 1;
   localparam int SEL_HI  = ADDR_W - 2;
   localparam int SEL_LO  = ADDR_W - 3;
   localparam int ABT_BIT = DATA_W - 1;

   if (REG_W < 5) begin : g_chk_reg_w
      $error("serial_bank_ctrl: REG_W must be at least 5");
   end
   if (PRG_W < 2 || PRG_W > REG_W) begin : g_chk_prg_w
      $error("serial_bank_ctrl: PRG_W must lie in 2..REG_W");
   end
   if (ADDR_W < 4) begin : g_chk_addr_w
      $error("serial_bank_ctrl: ADDR_W too small");
   end
   if (DATA_W < 2) begin : g_chk_data_w
      $error("serial_bank_ctrl: DATA_W too small");
   end

   logic             wr_hit;
   logic             abort_go;
   logic             commit;
   logic [REG_W-1:0] word;
   logic [CNT_W-1:0] ld_cnt;
   logic [REG_W-1:0] ctrl_w, chr0_w, chr1_w, prg_w;

   assign wr_hit   = wr_en & mode_en & wr_addr[WIN_BIT];
   assign abort_go = wr_hit & wr_data[ABT_BIT] & ~ser_clear;

   sbc_shift_loader #(
      .REG_W (REG_W),
      .CNT_W (CNT_W)
   ) u_loader (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (ser_clear),
      .wr_i     (wr_hit),
      .abort_i  (wr_data[ABT_BIT]),
      .bit_i    (wr_data[0]),
      .commit_o (commit),
      .word_o   (word),
      .cnt_o    (ld_cnt)
   );

   sbc_reg_bank #(
      .REG_W (REG_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (ser_clear),
      .abort_i  (abort_go),
      .commit_i (commit),
      .sel_i    (wr_addr[SEL_HI:SEL_LO]),
      .word_i   (word),
      .ctrl_o   (ctrl_w),
      .chr0_o   (chr0_w),
      .chr1_o   (chr1_w),
      .prg_o    (prg_w)
   );

   sbc_bank_map #(
      .REG_W   (REG_W),
      .PRG_W   (PRG_W),
      .OUT_REG (OUT_REG)
   ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_i   (ctrl_w),
      .chr0_i   (chr0_w),
      .chr1_i   (chr1_w),
      .prg_i    (prg_w),
      .prg_lo_o (prg_bank_lo),
      .prg_hi_o (prg_bank_hi),
      .chr_lo_o (chr_bank_lo),
      .chr_hi_o (chr_bank_hi),
      .mirror_o (mirror_mode)
   );

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int REG_W   = 5,
   parameter int CNT_W   = 3,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_en,
   input logic              ser_clear,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [CNT_W-1:0]  cnt,
   input logic [REG_W-1:0]  ctrl,
   input logic [REG_W-1:0]  prg,
   input logic [1:0]        mirror_mode
);

   logic acc;
   logic abt;
   assign acc = wr_en & mode_en & wr_addr[ADDR_W-1];
   assign abt = wr_data[DATA_W-1];

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(REG_W));

   p_commit_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !ser_clear && !abt && cnt == CNT_W'(REG_W - 1)) |=> (cnt == '0));

   p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc && !ser_clear) |=> ($stable(cnt) && $stable(ctrl) && $stable(prg)));

   p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && abt && !ser_clear) |=> (cnt == '0 && ctrl[3:2] == 2'b11));

   p_ext_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clear |=> (cnt == '0 && ctrl == REG_W'(12) && prg == '0));

   if (OUT_REG) begin : g_lag
      p_mirror_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $changed(ctrl[1:0]) |-> (mirror_mode == $past(ctrl[1:0])));
   end

endmodule

bind serial_bank_ctrl sbc_checker #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .REG_W   (REG_W),
   .CNT_W   (CNT_W),
   .OUT_REG (OUT_REG)
) u_sbc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_en     (mode_en),
   .ser_clear   (ser_clear),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .cnt         (ld_cnt),
   .ctrl        (ctrl_w),
   .prg         (prg_w),
   .mirror_mode (mirror_mode)
);

// File: tb/serial_bank_ctrl_tb.sv
module serial_bank_ctrl_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_en = 1'b1;
   logic        ser_clear = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [3:0]  prg_bank_lo, prg_bank_hi;
   logic [4:0]  chr_bank_lo, chr_bank_hi;
   logic [1:0]  mirror_mode;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // bench model of the four registers: 0 control, 1 chr0, 2 chr1, 3 program
   logic [4:0] m_reg [4];

   always #(CLK_PERIOD / 2) clk = ~clk;

   serial_bank_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_en     (mode_en),
      .ser_clear   (ser_clear),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .prg_bank_lo (prg_bank_lo),
      .prg_bank_hi (prg_bank_hi),
      .chr_bank_lo (chr_bank_lo),
      .chr_bank_hi (chr_bank_hi),
      .mirror_mode (mirror_mode)
   );

   task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input logic men);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      mode_en = men;
      @(negedge clk);
      wr_en   = 1'b0;
      mode_en = 1'b1;
   endtask

   function automatic logic [15:0] addr_of(input logic [1:0] sel, input int k);
      return {1'b1, sel, 13'(k * 371 + 9)};
   endfunction

   function automatic logic [7:0] data_of(input logic b, input int k, input int v);
      return {1'b0, 6'(k * 13 + v * 5 + 21), b};
   endfunction

   // one serial bit of a load for register sel
   task automatic ser_bit(input logic [1:0] sel, input int k, input logic [4:0] v);
      bus_wr(addr_of(sel, k), data_of(v[k], k, int'(v)), 1'b1);
   endtask

   task automatic ser_load(input logic [1:0] sel, input logic [4:0] v);
      for (int k = 0; k < 5; k++) ser_bit(sel, k, v);
      m_reg[sel] = v;
   endtask

   task automatic compare(input string req);
      logic [3:0] b, elo, ehi;
      logic [4:0] clo, chi;
      logic [4:0] c;
      c = m_reg[0];
      b = m_reg[3][3:0];
      if (!c[3]) begin elo = {b[3:1], 1'b0}; ehi = {b[3:1], 1'b1}; end
      else if (c[2]) begin elo = b; ehi = 4'd15; end
      else begin elo = 4'd0; ehi = b; end
      if (c[4]) begin clo = m_reg[1]; chi = m_reg[2]; end
      else begin clo = {m_reg[1][4:1], 1'b0}; chi = {m_reg[1][4:1], 1'b1}; end
      n_checks++;
      if (prg_bank_lo !== elo || prg_bank_hi !== ehi || chr_bank_lo !== clo ||
          chr_bank_hi !== chi || mirror_mode !== c[1:0]) begin
         n_fail++;
         $display("FAIL %s: prg=%0d/%0d exp %0d/%0d chr=%0d/%0d exp %0d/%0d mir=%0d exp %0d",
                  req, prg_bank_lo, prg_bank_hi, elo, ehi, chr_bank_lo, chr_bank_hi,
                  clo, chi, mirror_mode, c[1:0]);
      end
   endtask

   task automatic check_outs(input string req);
      @(negedge clk);
      compare(req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      m_reg[0] = 5'h0C; m_reg[1] = '0; m_reg[2] = '0; m_reg[3] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_outs("R1 reset state");

      // R2 R3 R7 R9: every control value against every program value
      for (int c = 0; c < 32; c++) begin
         ser_load(2'd0, 5'(c));
         check_outs("R3 R9 control commit");
         for (int p = 0; p < 32; p += 3) begin
            ser_load(2'd3, 5'(p));
            check_outs("R2 R7 program map");
         end
      end

      // R8: character registers in both window sizes
      for (int v = 0; v < 32; v++) begin
         ser_load(2'd1, 5'(v));
         ser_load(2'd2, 5'(31 - v));
         ser_load(2'd0, 5'((v[0] ? 16 : 0) | (v & 15)));
         check_outs("R8 R3 character map");
      end

      // R10: outputs lag the commit by one edge
      ser_load(2'd0, 5'h10);
      check_outs("R10 setup");
      for (int k = 0; k < 4; k++) ser_bit(2'd0, k, 5'h0F);
      ser_bit(2'd0, 4, 5'h0F);
      compare("R10 old value on commit edge");
      m_reg[0] = 5'h0F;
      check_outs("R10 new value one edge later");

      // R5: abort mid-load keeps bits 4,1,0 and restarts the counter
      ser_load(2'd0, 5'h11);
      ser_load(2'd3, 5'h06);
      ser_bit(2'd3, 0, 5'h1F);
      ser_bit(2'd3, 1, 5'h1F);
      ser_bit(2'd3, 2, 5'h1F);
      bus_wr(16'hE123, 8'h80, 1'b1);
      m_reg[0] = 5'h1D;
      check_outs("R5 abort forces control bits");
      ser_load(2'd3, 5'h09);
      check_outs("R5 counter restarted after abort");

      // R4: ignored writes, interleaved with a partial load
      ser_load(2'd0, 5'h1A);
      ser_load(2'd3, 5'h05);
      ser_bit(2'd3, 0, 5'h0B);
      ser_bit(2'd3, 1, 5'h0B);
      for (int k = 0; k < 5; k++) bus_wr(addr_of(2'd0, k), data_of(1'b1, k, 3), 1'b0);
      for (int k = 0; k < 5; k++) bus_wr({1'b0, 2'd0, 13'(k)}, 8'h81, 1'b1);
      check_outs("R4 writes without enable or window");
      ser_bit(2'd3, 2, 5'h0B);
      ser_bit(2'd3, 3, 5'h0B);
      ser_bit(2'd3, 4, 5'h0B);
      m_reg[3] = 5'h0B;
      check_outs("R4 partial load survived ignored writes");

      // R6: clear pulse alone, mid-load
      ser_load(2'd1, 5'h15);
      ser_load(2'd2, 5'h0A);
      ser_load(2'd0, 5'h13);
      ser_load(2'd3, 5'h09);
      ser_bit(2'd0, 0, 5'h1F);
      ser_bit(2'd0, 1, 5'h1F);
      @(negedge clk); ser_clear = 1'b1;
      @(negedge clk); ser_clear = 1'b0;
      m_reg[0] = 5'h0C; m_reg[3] = 5'h00;
      check_outs("R6 clear pulse");
      ser_load(2'd0, 5'h12);
      check_outs("R6 counter cleared by pulse");

      // R6: clear on the same edge as a fifth write
      for (int k = 0; k < 4; k++) ser_bit(2'd0, k, 5'h1B);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr_of(2'd0, 4); wr_data = data_of(1'b1, 4, 0);
      ser_clear = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; ser_clear = 1'b0;
      m_reg[0] = 5'h0C; m_reg[3] = 5'h00;
      check_outs("R6 clear beats fifth write");
      ser_load(2'd3, 5'h0E);
      check_outs("R6 load after collision");

      finish_run();
   end

endmodule